// File: doc/BRIEF.md
# SPI Transfer Buffer Pair

This block sits between a register-style host port and an SPI shift engine and holds the words flowing in each direction. The transmit queue keeps every word the host writes until the shift engine reports that the transfer carrying it has completed. An aborted transfer therefore leaves the word at the head, ready for a retry. The receive queue is filled by the block itself: each completed transfer deposits the engine's shift-register word.

The host sees one write strobe and one read strobe. Each access returns an acknowledge one cycle later. An error flag comes with that acknowledge when the access was illegal: a write while the transmit queue is full, or a read while the receive queue is empty. The engine asks for the head word with a request strobe and ends each transfer with a done strobe. An abort strobe raised with done turns the completion into an abort. Both occupancy counts are visible as outputs. Five one-cycle interrupt strobes mark the notable queue events. A FIFO-clear input empties both queues without a full reset.

Top module: `spi_xfer_fifo_pair`

## Requirements
- R1: After `rst` or a one-cycle `fifo_clr`, both counts read 0, and an empty receive queue then answers a host read with an error.
- R2: A host write while `tx_count` is below 16 is acknowledged on the next cycle without error, and `tx_count` rises by one.
- R3: A host write while `tx_count` is 16 is acknowledged with `host_err` high, stores nothing and leaves the count at 16.
- R4: Transmit words leave in write order. A request returns the head word on `eng_tx_data` in the cycle after it. The head is removed only by `eng_done` with `eng_abort` low. `eng_abort`, alone or with `eng_done`, leaves the count and the head unchanged, and nothing is deposited in the receive queue.
- R5: A request while the transmit queue is empty returns all-zero data and pulses `irq_tx_underrun` for one cycle.
- R6: `irq_tx_empty` pulses for one cycle when a completed transfer takes `tx_count` from 1 to 0.
- R7: `irq_tx_half` pulses for one cycle when a completed transfer takes `tx_count` from 9 to 8 (from half depth plus one to half depth).
- R8: A completed transfer with the receive queue not full stores `eng_rx_data` and raises `rx_count` by one. A host read returns the words in arrival order on `host_rd_data` with the acknowledge and lowers `rx_count` by one.
- R9: A host read while `rx_count` is 0 is acknowledged with `host_err` high, returns 0 and leaves the count at 0.
- R10: `irq_rx_full` pulses for one cycle when a completed transfer takes `rx_count` from 15 to 16.
- R11: A completed transfer while `rx_count` is 16 pulses `irq_rx_overflow` for one cycle and discards the word. The count stays 16.
- R12: Every interrupt output is high for exactly one cycle for each event.
- R13: A host write and a completed transfer in the same cycle leave `tx_count` unchanged, so the host can keep refilling while the queue drains. The counts are 5 bits wide, from 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Synchronous clear of both queues |
| host_wr_en | input | 1 | Host write strobe into the transmit queue |
| host_wr_data | input | 8 | Host write word |
| host_rd_en | input | 1 | Host read strobe from the receive queue |
| host_rd_data | output | 8 | Read word, valid with the acknowledge |
| host_ack | output | 1 | Acknowledge, one cycle after any access |
| host_err | output | 1 | Illegal-access flag, given with the acknowledge |
| eng_tx_req | input | 1 | Engine asks for the head transmit word |
| eng_tx_data | output | 8 | Head word, valid the cycle after a request |
| eng_done | input | 1 | Engine finished a transfer |
| eng_abort | input | 1 | The transfer was aborted, so the done does not count |
| eng_rx_data | input | 8 | Shift-register word, sampled with done |
| tx_count | output | 5 | Transmit occupancy |
| rx_count | output | 5 | Receive occupancy |
| irq_tx_empty | output | 1 | Transmit queue drained |
| irq_tx_half | output | 1 | Transmit queue fell to half |
| irq_tx_underrun | output | 1 | Request made on an empty transmit queue |
| irq_rx_full | output | 1 | Receive queue became full |
| irq_rx_overflow | output | 1 | Received word dropped |

## Verification
The assertions check on every cycle that the counts stay within the depth and that a write refused while full, or an abort, leaves the transmit count stable. They also check that every drain, full and overflow strobe agrees with the occupancy beside it, and that each error comes with an acknowledge. Only the bench scenarios can show data ordering, that the head survives an abort, and that refused and overflowed words never reappear. They also cover the exact thresholds of the half-empty and full strobes.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned SFP_DATA_W = 8;
  localparam int unsigned SFP_DEPTH  = 16;

  function automatic int unsigned sfp_half(int unsigned depth);
    return depth / 2;
  endfunction
endpackage

// File: rtl/sfp_ring.sv
module sfp_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  // R13: occupancy never exceeds the depth
  assert_count_bound_R13: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R3: a push refused while full cannot raise the count
  assert_no_push_when_full_R3: assert property (@(posedge clk) disable iff (rst || clr)
    (push && full && !pop) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/sfp_tx_side.sv
module sfp_tx_side #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              is_full,
  input  logic              eng_req,
  input  logic              eng_done,
  input  logic              eng_abort,
  output logic [DATA_W-1:0] eng_data,
  output logic [CNT_W-1:0]  count,
  output logic              irq_empty,
  output logic              irq_half,
  output logic              irq_underrun
);
  localparam int HALF = sfp_pkg::sfp_half(DEPTH);

  logic              completed, push_ok, is_empty, under_q;
  logic [DATA_W-1:0] raw;

  assign completed = eng_done & ~eng_abort;
  assign push_ok   = wr_en & ~is_full;

  sfp_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ring_i (
    .clk(clk), .rst(rst), .clr(clr),
    .push(wr_en), .push_data(wr_data),
    .pop(completed),
    .rd_en(eng_req), .rd_data(raw),
    .count(count), .full(is_full), .empty(is_empty)
  );

  assign eng_data = under_q ? '0 : raw;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      under_q      <= 1'b0;
      irq_empty    <= 1'b0;
      irq_half     <= 1'b0;
      irq_underrun <= 1'b0;
    end else begin
      if (eng_req) under_q <= is_empty;
      irq_empty    <= completed & ~push_ok & (count == CNT_W'(1));
      irq_half     <= completed & ~push_ok & (count == CNT_W'(HALF + 1));
      irq_underrun <= eng_req & is_empty;
    end
  end

  // R4: an abort with no host write leaves the occupancy untouched
  assert_abort_keeps_count_R4: assert property (@(posedge clk) disable iff (rst || clr)
    (eng_abort && !wr_en) |=> $stable(count));

  // R6: the drain strobe only appears with an empty queue
  assert_empty_irq_count_R6: assert property (@(posedge clk) disable iff (rst)
    irq_empty |-> (count == '0));

  // R5: an underrun strobe always comes with zero data
  assert_underrun_zero_R5: assert property (@(posedge clk) disable iff (rst)
    irq_underrun |-> (eng_data == '0));

  // R7: the half strobe appears at exactly half occupancy
  assert_half_irq_count_R7: assert property (@(posedge clk) disable iff (rst)
    irq_half |-> (count == CNT_W'(HALF)));
endmodule

// File: rtl/sfp_rx_side.sv
module sfp_rx_side #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              is_empty,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] xfer_data,
  output logic [CNT_W-1:0]  count,
  output logic              irq_full,
  output logic              irq_overflow
);
  logic              is_full, pop_ok, empty_q;
  logic [DATA_W-1:0] raw;

  assign pop_ok = rd_en & ~is_empty;

  sfp_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ring_i (
    .clk(clk), .rst(rst), .clr(clr),
    .push(xfer_done), .push_data(xfer_data),
    .pop(rd_en),
    .rd_en(rd_en), .rd_data(raw),
    .count(count), .full(is_full), .empty(is_empty)
  );

  assign rd_data = empty_q ? '0 : raw;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      empty_q      <= 1'b1;
      irq_full     <= 1'b0;
      irq_overflow <= 1'b0;
    end else begin
      if (rd_en) empty_q <= is_empty;
      irq_full     <= xfer_done & ~is_full & ~pop_ok & (count == CNT_W'(DEPTH - 1));
      irq_overflow <= xfer_done & is_full;
    end
  end

  // R10: the full strobe only appears with a full queue
  assert_full_irq_count_R10: assert property (@(posedge clk) disable iff (rst)
    irq_full |-> (count == CNT_W'(DEPTH)));

  // R11: overflow only follows a cycle in which the queue was full
  assert_overflow_was_full_R11: assert property (@(posedge clk) disable iff (rst || clr)
    irq_overflow |-> ($past(count) == CNT_W'(DEPTH)));
endmodule

// File: rtl/spi_xfer_fifo_pair.sv
module spi_xfer_fifo_pair #(
  parameter int DATA_W = sfp_pkg::SFP_DATA_W,
  parameter int DEPTH  = sfp_pkg::SFP_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_clr,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              host_ack,
  output logic              host_err,
  input  logic              eng_tx_req,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_done,
  input  logic              eng_abort,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count,
  output logic              irq_tx_empty,
  output logic              irq_tx_half,
  output logic              irq_tx_underrun,
  output logic              irq_rx_full,
  output logic              irq_rx_overflow
);
  logic tx_full, rx_empty, xfer_ok;

  assign xfer_ok = eng_done & ~eng_abort;

  sfp_tx_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_i (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .wr_en(host_wr_en), .wr_data(host_wr_data), .is_full(tx_full),
    .eng_req(eng_tx_req), .eng_done(eng_done), .eng_abort(eng_abort),
    .eng_data(eng_tx_data), .count(tx_count),
    .irq_empty(irq_tx_empty), .irq_half(irq_tx_half), .irq_underrun(irq_tx_underrun)
  );

  sfp_rx_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_i (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .rd_en(host_rd_en), .rd_data(host_rd_data), .is_empty(rx_empty),
    .xfer_done(xfer_ok), .xfer_data(eng_rx_data), .count(rx_count),
    .irq_full(irq_rx_full), .irq_overflow(irq_rx_overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ack <= 1'b0;
      host_err <= 1'b0;
    end else begin
      host_ack <= host_wr_en | host_rd_en;
      host_err <= (host_wr_en & tx_full) | (host_rd_en & rx_empty);
    end
  end

  // R3, R9: an error is never given without its acknowledge
  assert_err_with_ack_R9: assert property (@(posedge clk) disable iff (rst)
    host_err |-> host_ack);

  // R2: each acknowledge answers an access one cycle earlier
  assert_ack_follows_access_R2: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> $past(host_wr_en || host_rd_en));
endmodule

// File: tb/spi_xfer_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_fifo_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst, fifo_clr;
  logic       host_wr_en, host_rd_en, eng_tx_req, eng_done, eng_abort;
  logic [7:0] host_wr_data, eng_rx_data;
  logic [7:0] host_rd_data, eng_tx_data;
  logic       host_ack, host_err;
  logic [4:0] tx_count, rx_count;
  logic       irq_tx_empty, irq_tx_half, irq_tx_underrun, irq_rx_full, irq_rx_overflow;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_xfer_fifo_pair dut_i (
    .clk(clk), .rst(rst), .fifo_clr(fifo_clr),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .host_ack(host_ack), .host_err(host_err),
    .eng_tx_req(eng_tx_req), .eng_tx_data(eng_tx_data),
    .eng_done(eng_done), .eng_abort(eng_abort), .eng_rx_data(eng_rx_data),
    .tx_count(tx_count), .rx_count(rx_count),
    .irq_tx_empty(irq_tx_empty), .irq_tx_half(irq_tx_half),
    .irq_tx_underrun(irq_tx_underrun), .irq_rx_full(irq_rx_full),
    .irq_rx_overflow(irq_rx_overflow)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic host_write(logic [7:0] d, bit exp_err, string tag);
    host_wr_en = 1'b1; host_wr_data = d;
    step();
    host_wr_en = 1'b0;
    check({tag, " ack"}, host_ack, 1);
    check({tag, " err"}, host_err, exp_err);
  endtask

  task automatic host_read(logic [7:0] exp_d, bit exp_err, string tag);
    host_rd_en = 1'b1;
    step();
    host_rd_en = 1'b0;
    check({tag, " ack"}, host_ack, 1);
    check({tag, " err"}, host_err, exp_err);
    check({tag, " data"}, host_rd_data, exp_d);
  endtask

  task automatic peek(logic [7:0] exp_d, string tag);
    eng_tx_req = 1'b1;
    step();
    eng_tx_req = 1'b0;
    check({tag, " head"}, eng_tx_data, exp_d);
  endtask

  task automatic xfer(logic [7:0] rxw, bit abort);
    eng_done = 1'b1; eng_abort = abort; eng_rx_data = rxw;
    step();
    eng_done = 1'b0; eng_abort = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset tx_count", tx_count, 0);
    check("R1 reset rx_count", rx_count, 0);
    check("R1 reset irqs", {irq_tx_empty, irq_tx_half, irq_tx_underrun, irq_rx_full, irq_rx_overflow}, 0);
    check("R1 reset ack", host_ack, 0);
  endtask

  task automatic t_basic();
    host_write(8'hA1, 0, "R2 w1");
    host_write(8'hA2, 0, "R2 w2");
    host_write(8'hA3, 0, "R2 w3");
    check("R2 tx_count", tx_count, 3);
    peek(8'hA1, "R4 first");
    eng_abort = 1'b1; step(); eng_abort = 1'b0;
    check("R4 abort alone count", tx_count, 3);
    xfer(8'h11, 1);
    check("R4 abort with done count", tx_count, 3);
    check("R4 abort no rx deposit", rx_count, 0);
    peek(8'hA1, "R4 head kept");
    xfer(8'h5A, 0);
    check("R4 pop count", tx_count, 2);
    check("R8 rx deposit", rx_count, 1);
    check("R6 no early empty", irq_tx_empty, 0);
    peek(8'hA2, "R4 order");
    xfer(8'h5B, 0);
    xfer(8'h5C, 0);
    check("R6 drained", tx_count, 0);
    check("R6 empty irq", irq_tx_empty, 1);
    step();
    check("R12 empty pulse ends", irq_tx_empty, 0);
    host_read(8'h5A, 0, "R8 r1");
    host_read(8'h5B, 0, "R8 r2");
    host_read(8'h5C, 0, "R8 r3");
    check("R8 rx_count", rx_count, 0);
    host_read(8'h00, 1, "R9 empty read");
    check("R9 count stays", rx_count, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) host_write(8'(i), 0, "R2 fill");
    check("R13 tx full count", tx_count, 16);
    host_write(8'hEE, 1, "R3 full write");
    check("R3 count stays", tx_count, 16);
    for (int i = 0; i < 16; i++) begin
      peek(8'(i), "R3 R4 drain order");
      xfer(8'(8'h30 + i), 0);
      if (i == 6) check("R7 no half yet", irq_tx_half, 0);
      if (i == 7) begin
        check("R7 half irq", irq_tx_half, 1);
        check("R7 count", tx_count, 8);
      end
      if (i == 8) check("R12 half pulse ends", irq_tx_half, 0);
      if (i == 14) check("R10 no full yet", irq_rx_full, 0);
    end
    check("R6 empty irq", irq_tx_empty, 1);
    check("R10 rx full irq", irq_rx_full, 1);
    check("R10 rx count", rx_count, 16);
    host_write(8'h77, 0, "R2 refill");
    check("R12 full pulse ends", irq_rx_full, 0);
    peek(8'h77, "R3 refused word absent");
    xfer(8'h99, 0);
    check("R11 overflow irq", irq_rx_overflow, 1);
    check("R11 count stays", rx_count, 16);
    step();
    check("R12 overflow pulse ends", irq_rx_overflow, 0);
    for (int i = 0; i < 16; i++) host_read(8'(8'h30 + i), 0, "R8 R11 rx order");
    check("R11 dropped word absent", rx_count, 0);
  endtask

  task automatic t_underrun();
    check("R5 precondition", tx_count, 0);
    peek(8'h00, "R5 underrun data");
    check("R5 underrun irq", irq_tx_underrun, 1);
    step();
    check("R12 underrun pulse ends", irq_tx_underrun, 0);
  endtask

  task automatic t_concurrent();
    host_write(8'h21, 0, "R13 w");
    host_wr_en = 1'b1; host_wr_data = 8'h22;
    eng_done = 1'b1; eng_rx_data = 8'h44;
    step();
    host_wr_en = 1'b0; eng_done = 1'b0;
    check("R13 concurrent count", tx_count, 1);
    check("R13 no empty irq", irq_tx_empty, 0);
    peek(8'h22, "R13 new head");
    check("R8 concurrent rx", rx_count, 1);
  endtask

  task automatic t_clear();
    host_write(8'h55, 0, "R1 pre");
    fifo_clr = 1'b1; step(); fifo_clr = 1'b0;
    check("R1 clr tx_count", tx_count, 0);
    check("R1 clr rx_count", rx_count, 0);
    host_read(8'h00, 1, "R1 read after clr");
  endtask

  initial begin
    rst = 1'b1; fifo_clr = 1'b0;
    host_wr_en = 1'b0; host_rd_en = 1'b0; host_wr_data = '0;
    eng_tx_req = 1'b0; eng_done = 1'b0; eng_abort = 1'b0; eng_rx_data = '0;
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_basic();
    t_full();
    t_underrun();
    t_concurrent();
    t_clear();
    repeat (2) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule